// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block collects single-cycle event pulses from eight interrupt sources. Each pulse sets a sticky bit in a status register. The status bits that the mask register enables are OR-combined into one interrupt pin. A control register chooses the pin polarity. It also sets a capture mode, in which masked events are still written into status but cannot drive the pin. A bus-side read of the status register returns its contents and clears every bit in the same access.

Two sources form an exclusive pair, lock (bit 6) and unlock (bit 7). Latching either one removes the other. Source bit 5 carries two meanings. While the `in_sleep` input is high, a wake-complete pulse drives it. While `in_sleep` is low, a measurement-done pulse drives it. The generic pulse on `src_evt[5]` is always accepted as well.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pin is inactive (low), and reads of status, mask and control all return 0.
- R2: An event on an enabled source sets its status bit on the next clock edge. The bit stays set after the pulse ends. The pin asserts one clock after the status bit is set.
- R3: When capture mode is off, an event on a source whose mask bit is 0 is discarded. Its status bit stays 0.
- R4: When capture mode (control bit 1) is set, an event on a masked source is latched into status but does not assert the pin.
- R5: A status read (address 0) returns the value status had in the cycle of the read, on `reg_rdata`, with `reg_rvalid` high one cycle after `reg_rd`. The same read clears all status bits, and the pin deasserts one clock later.
- R6: An event that arrives in the same cycle as a clearing read is not returned by that read, stays set afterwards, and is returned by the next read.
- R7: Control bit 0 set makes the pin active-low. The pin then idles high and goes low while any enabled status bit is set.
- R8: Latching lock (bit 6) clears unlock (bit 7), and latching unlock clears lock. If both arrive in the same cycle, lock is kept and unlock is dropped.
- R9: Source bit 5 is set by `wake_evt` only while `in_sleep`=1, and by `meas_evt` only while `in_sleep`=0.
- R10: The register map is as follows. Address 0 is status and is read-only, so writes to it are ignored. Address 1 is mask, which reads back what was written. Address 2 is control, with bits [1:0] used. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| src_evt | input | 8 | Event pulses, one per source |
| wake_evt | input | 1 | Wake-complete pulse for shared source 5 |
| meas_evt | input | 1 | Measurement-done pulse for shared source 5 |
| in_sleep | input | 1 | Selects which shared-source pulse counts |
| irq_pin | output | 1 | Interrupt pin, registered |

## Verification
The bench builds the block with its default parameters: eight sources, lock at 6, unlock at 7 and the shared source at 5. With these values the exclusive pair and the state-dependent source can be reached from ordinary pulses on the top-level ports. Every source fits in one 8-bit register, so a single read shows the whole status at once. Reads are scoreboarded against values derived from the requirements. This includes the read that coincides with a new event, where the returned value must exclude that event.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam int CTRL_LOW_BIT = 0;
  localparam int CTRL_CAP_BIT = 1;
endpackage

// File: rtl/irq_event_merge.sv
module irq_event_merge #(
  parameter int NUM_SRC    = 8,
  parameter int LOCK_IDX   = 6,
  parameter int UNLOCK_IDX = 7,
  parameter int SHARED_IDX = 5
) (
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               wake_evt,
  input  logic               meas_evt,
  input  logic               in_sleep,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               cap_mode,
  output logic [NUM_SRC-1:0] set_o,
  output logic [NUM_SRC-1:0] kill_o
);
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] en;

  always_comb begin
    raw = src_evt;
    raw[SHARED_IDX] = src_evt[SHARED_IDX] | (in_sleep ? wake_evt : meas_evt);
    en = raw & (mask | {NUM_SRC{cap_mode}});
    set_o  = en;
    kill_o = '0;
    if (en[LOCK_IDX]) begin
      set_o[UNLOCK_IDX]  = 1'b0;
      kill_o[UNLOCK_IDX] = 1'b1;
    end else if (en[UNLOCK_IDX]) begin
      kill_o[LOCK_IDX] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC    = 8,
  parameter int LOCK_IDX   = 6,
  parameter int UNLOCK_IDX = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] kill_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        status_o[i] <= 1'b0;
      else if (set_i[i])
        status_o[i] <= 1'b1;
      else if (clr_i || kill_i[i])
        status_o[i] <= 1'b0;
    end
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && kill_i == '0) |=> ((status_o & $past(status_o)) == $past(status_o)));
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_o & $past(set_i)) == $past(set_i)));
  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && set_i == '0) |=> (status_o == '0));
  // R8
  pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(status_o[LOCK_IDX] && status_o[UNLOCK_IDX]));
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               active_low_i,
  output logic               pin_o
);
  always_ff @(posedge clk) begin
    if (rst) pin_o <= 1'b0;
    else     pin_o <= (|(status_i & mask_i)) ^ active_low_i;
  end

  // R7
  pin_level_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_o == ($past(|(status_i & mask_i)) ^ $past(active_low_i))));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int LOCK_IDX   = 6,
  parameter int UNLOCK_IDX = 7,
  parameter int SHARED_IDX = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               reg_rvalid,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               wake_evt,
  input  logic               meas_evt,
  input  logic               in_sleep,
  output logic               irq_pin
);
  localparam int CTRL_W = 2;

  logic [NUM_SRC-1:0] mask_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] set_v;
  logic [NUM_SRC-1:0] kill_v;
  logic               status_rd;

  assign status_rd = reg_rd && (reg_addr == ADDR_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_MASK) mask_q <= reg_wdata;
      if (reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          ADDR_STATUS: reg_rdata <= status_q;
          ADDR_MASK:   reg_rdata <= mask_q;
          ADDR_CTRL:   reg_rdata <= {{(NUM_SRC-CTRL_W){1'b0}}, ctrl_q};
          default:     reg_rdata <= '0;
        endcase
      end
    end
  end

  irq_event_merge #(
    .NUM_SRC(NUM_SRC), .LOCK_IDX(LOCK_IDX),
    .UNLOCK_IDX(UNLOCK_IDX), .SHARED_IDX(SHARED_IDX)
  ) u_merge (
    .src_evt(src_evt), .wake_evt(wake_evt), .meas_evt(meas_evt),
    .in_sleep(in_sleep), .mask(mask_q), .cap_mode(ctrl_q[CTRL_CAP_BIT]),
    .set_o(set_v), .kill_o(kill_v)
  );

  irq_status_bank #(
    .NUM_SRC(NUM_SRC), .LOCK_IDX(LOCK_IDX), .UNLOCK_IDX(UNLOCK_IDX)
  ) u_status (
    .clk(clk), .rst(rst), .clr_i(status_rd),
    .set_i(set_v), .kill_i(kill_v), .status_o(status_q)
  );

  irq_pin_drive #(.NUM_SRC(NUM_SRC)) u_pin (
    .clk(clk), .rst(rst), .status_i(status_q), .mask_i(mask_q),
    .active_low_i(ctrl_q[CTRL_LOW_BIT]), .pin_o(irq_pin)
  );

  // R5
  rvalid_origin_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rvalid |-> $past(reg_rd));
  // R3
  masked_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CTRL_CAP_BIT] && !status_rd) |=>
      ((status_q & ~$past(status_q) & ~$past(mask_q)) == '0));
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       reg_rvalid;
  logic [7:0] src_evt = 8'h00;
  logic       wake_evt = 1'b0, meas_evt = 1'b0, in_sleep = 1'b0;
  logic       irq_pin;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .src_evt(src_evt), .wake_evt(wake_evt),
    .meas_evt(meas_evt), .in_sleep(in_sleep), .irq_pin(irq_pin)
  );

  // monitor: pop expected read data as it appears
  always @(negedge clk) begin
    if (reg_rvalid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data: actual %h expected none", reg_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s read: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    src_evt = e;
    @(negedge clk);
    src_evt = 8'h00;
  endtask

  task automatic check_pin(input logic e, input string t);
    @(negedge clk);
    n_checks++;
    if (irq_pin !== e) begin
      n_fail++;
      $display("FAIL %s pin: actual %b expected %b", t, irq_pin, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_pin(1'b0, "R1");
    rd(2'd0, 8'h00, "R1 status");
    rd(2'd1, 8'h00, "R1 mask");
    rd(2'd2, 8'h00, "R1 ctrl");
    // R3 all masked, capture off
    pulse(8'hFF);
    check_pin(1'b0, "R3");
    rd(2'd0, 8'h00, "R3");
    // R10 mask readback, status write ignored, addr 3
    wr(2'd1, 8'h05);
    rd(2'd1, 8'h05, "R10 mask");
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'h00, "R10 status write");
    rd(2'd3, 8'h00, "R10 addr3");
    // R2 sticky, pin one cycle after status
    pulse(8'h01);
    n_checks++;
    if (irq_pin !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 pin early: actual %b expected 0", irq_pin);
    end
    check_pin(1'b1, "R2");
    pulse(8'h02);
    check_pin(1'b1, "R2 hold");
    // R5 read returns and clears
    rd(2'd0, 8'h01, "R5/R3");
    check_pin(1'b0, "R5");
    rd(2'd0, 8'h00, "R5 cleared");
    // R4 capture mode
    wr(2'd2, 8'h02);
    rd(2'd2, 8'h02, "R10 ctrl");
    pulse(8'h02);
    check_pin(1'b0, "R4");
    rd(2'd0, 8'h02, "R4");
    wr(2'd2, 8'h00);
    // R6 event with read same cycle
    wr(2'd1, 8'h03);
    pulse(8'h02);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'd0; src_evt = 8'h01;
    exp_q.push_back(8'h02); tag_q.push_back("R6 first");
    @(negedge clk);
    reg_rd = 1'b0; src_evt = 8'h00;
    rd(2'd0, 8'h01, "R6 kept");
    // R7 active-low
    wr(2'd2, 8'h01);
    check_pin(1'b1, "R7 idle");
    pulse(8'h01);
    check_pin(1'b0, "R7 active");
    rd(2'd0, 8'h01, "R7");
    check_pin(1'b1, "R7 released");
    wr(2'd2, 8'h00);
    // R8 lock/unlock
    wr(2'd1, 8'hC0);
    pulse(8'h40);
    pulse(8'h80);
    rd(2'd0, 8'h80, "R8 unlock clears lock");
    pulse(8'h80);
    pulse(8'h40);
    rd(2'd0, 8'h40, "R8 lock clears unlock");
    pulse(8'hC0);
    rd(2'd0, 8'h40, "R8 both");
    // R9 shared source
    wr(2'd1, 8'h20);
    in_sleep = 1'b1;
    @(negedge clk); meas_evt = 1'b1; @(negedge clk); meas_evt = 1'b0;
    rd(2'd0, 8'h00, "R9 meas asleep");
    @(negedge clk); wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    rd(2'd0, 8'h20, "R9 wake asleep");
    in_sleep = 1'b0;
    @(negedge clk); wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    rd(2'd0, 8'h00, "R9 wake awake");
    @(negedge clk); meas_evt = 1'b1; @(negedge clk); meas_evt = 1'b0;
    rd(2'd0, 8'h20, "R9 meas awake");
    repeat (3) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5 pending reads: actual %0d expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule